// File: doc/BRIEF.md
# Shared Instruction Cache with Lock and Bypass Modes

This block is a read-only cache that sits between two processor fetch ports (instruction fetch and data-code fetch) and a slower backing memory. It holds 8 KB as 64 sets of four 32-byte lines. A lookup that hits answers in the same cycle it is requested. A lookup that misses fetches the whole line from memory as an 8-beat burst, answers the requester as soon as its word arrives, and then installs the line in place of the least-recently-used way of its set.

Two control inputs change how misses and hits are handled. When the enable input is low, the cache is bypassed and every access becomes a single-word memory read. The lock input keeps the cache contents fixed: hits are still served, and a miss becomes a single-word read that allocates and evicts nothing. A one-cycle invalidate input empties the cache when no memory read is outstanding.

Each fetch port holds its request and address until it sees an acknowledge pulse. The read data is valid in that same cycle.

Top module: `icache_ctrl`

## Requirements
- R1: The geometry is 4 ways × 64 sets × 32-byte lines of eight 32-bit words. A byte address splits into the word select in bits [4:2], the set index in bits [10:5] and the tag in bits [31:11].
- R2: A request that hits while enable is high is acknowledged in the same cycle it is presented, with the addressed word.
- R3: On a miss while enable is high and lock is low, a single mem_req_o pulse is issued with mem_burst_o=1 at the line-aligned address. Beats return in ascending word order, and the requester is acknowledged in the cycle that its word's beat arrives, with that beat's data. After the last beat the line hits.
- R4: The line being filled replaces the least-recently-used way of its set. Recency is updated on every hit and on every fill. After reset, ways are filled in order 0, 1, 2, 3.
- R5: Both fetch ports look up the same contents, so a line filled through one port hits from the other.
- R6: When both ports request in the same cycle, only one is acknowledged. The instruction port wins unless the data-code port lost the previous such conflict. The losing port is served in the following cycle.
- R7: While lock is high, hits are served as normal. A miss issues one single-word read (mem_burst_o=0) and is acknowledged with the returned word. No line is allocated or evicted.
- R8: While enable is low, every request issues a single-word read at the word-aligned address, whether or not the line is resident. The contents are kept and hit again after enable returns high.
- R9: An invalidate pulse while no memory read is outstanding makes every line miss from the next cycle. An invalidate pulse during a memory read has no effect.
- R10: After reset, no acknowledge and no memory request are asserted, and every line misses.
- R11: While a memory read is outstanding, the port that does not own it is not acknowledged, even for a resident line. It is served once the read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Cache enable; low bypasses the cache |
| lock_i | input | 1 | Freeze contents; misses do not allocate |
| inv_i | input | 1 | Invalidate all lines |
| i_req_i | input | 1 | Instruction port request, held until acknowledge |
| i_addr_i | input | 32 | Instruction port byte address |
| i_ack_o | output | 1 | Instruction port acknowledge |
| i_rdata_o | output | 32 | Instruction port read data |
| d_req_i | input | 1 | Data-code port request, held until acknowledge |
| d_addr_i | input | 32 | Data-code port byte address |
| d_ack_o | output | 1 | Data-code port acknowledge |
| d_rdata_o | output | 32 | Data-code port read data |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_burst_o | output | 1 | 1 = 8-beat line read, 0 = single word |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Memory read beat valid |
| mem_rdata_i | input | 32 | Memory read beat data |

## Verification
A hit is due in the same cycle as its request, and the bench requires a latency of zero cycles. Memory answers two cycles after the request cycle. A pass-through read is therefore due three cycles after the request, and a filling miss is due three cycles plus the requested word's position in the line. For every transaction the scoreboard records the cycle in which the request was raised, and the monitor compares the acknowledge cycle exactly with that figure. For the stalled port in a fill and for the loser of a conflict, the bench computes the extra cycles from the fill length or from the one-cycle arbitration delay.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_PASS
  } ic_state_e;
endpackage

// File: rtl/icache_arb.sv
module icache_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,   // [0] instruction, [1] data-code
  input  logic       take_i,  // grant is consumed this cycle
  output logic [1:0] gnt_o
);
  logic prio_d_q;
  logic conflict;

  assign conflict = &req_i;
  assign gnt_o    = conflict ? (prio_d_q ? 2'b10 : 2'b01) : req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   prio_d_q <= 1'b0;
    else if (take_i && conflict)   prio_d_q <= !prio_d_q;
  end

  AST_GNT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R6
  AST_LOSER_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict && take_i && gnt_o[0]) |=> (!(&req_i) || gnt_o[1])); // R6
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PAIRS = WAYS * (WAYS - 1) / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  // bit of pair (a,b), a<b: 1 = way a used more recently than way b
  logic [PAIRS-1:0] lru_q [SETS];
  logic [PAIRS-1:0] row, nxt;
  logic [WAYS-1:0]  victim_oh;

  function automatic int pidx(input int a, input int b);
    return a * (2 * WAYS - a - 1) / 2 + (b - a - 1);
  endfunction

  always_comb begin
    row       = lru_q[rd_set_i];
    victim_oh = '1;
    for (int a = 0; a < WAYS; a++)
      for (int b = a + 1; b < WAYS; b++)
        if (row[pidx(a, b)]) victim_oh[a] = 1'b0;
        else                 victim_oh[b] = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (victim_oh[w]) victim_o = WAY_W'(w);
  end

  always_comb begin
    nxt = lru_q[touch_set_i];
    for (int a = 0; a < WAYS; a++)
      for (int b = a + 1; b < WAYS; b++)
        if (WAY_W'(a) == touch_way_i)      nxt[pidx(a, b)] = 1'b1;
        else if (WAY_W'(b) == touch_way_i) nxt[pidx(a, b)] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (touch_i) begin
      lru_q[touch_set_i] <= nxt;
    end
  end

  AST_VICTIM_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(victim_oh)); // R4
  AST_MRU_SPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (rd_set_i != $past(touch_set_i)) || (victim_o != $past(touch_way_i))); // R4
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 21,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int DEPTH  = SETS * WAYS * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [WSEL_W-1:0] lk_word_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WSEL_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              inv_i
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [SETS*WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   hit_vec;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[lk_idx_i][w] && (tag_q[{lk_idx_i, WAY_W'(w)}] == lk_tag_i);
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign hit_o      = |hit_vec;
  assign hit_data_o = data_q[{lk_idx_i, hit_way_o, lk_word_i}];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[{wr_idx_i, wr_way_i, wr_word_i}] <= wr_data_i;
    if (alloc_i) tag_q[{wr_idx_i, wr_way_i}] <= alloc_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (inv_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (alloc_i) begin
      valid_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  AST_HIT_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R4
  AST_INV_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !alloc_i) |=> !hit_o); // R9
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              lock_i,
  input  logic              inv_i,
  input  logic              i_req_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  output logic              i_ack_o,
  output logic [DATA_W-1:0] i_rdata_o,
  input  logic              d_req_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  output logic              d_ack_o,
  output logic [DATA_W-1:0] d_rdata_o,
  output logic              mem_req_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int WORD_B = DATA_W / 8;
  localparam int BSEL_W = $clog2(WORD_B);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BSEL_W + WSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(WORD_B - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(WORD_B * LINE_WORDS - 1);

  ic_state_e state_q, state_d;
  logic [1:0]        req, gnt;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  lk_idx, idx_q;
  logic [TAG_W-1:0]  lk_tag, tag_q;
  logic [WSEL_W-1:0] lk_word, word_q, beat_q;
  logic [WAY_W-1:0]  way_q, victim, hit_way;
  logic              hit;
  logic [DATA_W-1:0] hit_data;
  logic              own_q, sent_q;
  logic              ack, ack_port;
  logic [DATA_W-1:0] rdata;
  logic              wr_en, alloc, touch;
  logic [IDX_W-1:0]  touch_set;
  logic [WAY_W-1:0]  touch_way;
  logic              last_beat;

  assign req      = {d_req_i, i_req_i};
  assign sel_addr = gnt[1] ? d_addr_i : i_addr_i;
  assign lk_idx   = sel_addr[OFF_W +: IDX_W];
  assign lk_tag   = sel_addr[ADDR_W-1 -: TAG_W];
  assign lk_word  = sel_addr[BSEL_W +: WSEL_W];
  assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));

  icache_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .take_i (state_q == ST_IDLE),
    .gnt_o  (gnt)
  );

  icache_store #(
    .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (lk_idx),
    .lk_tag_i    (lk_tag),
    .lk_word_i   (lk_word),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .hit_data_o  (hit_data),
    .wr_en_i     (wr_en),
    .wr_idx_i    (idx_q),
    .wr_way_i    (way_q),
    .wr_word_i   (beat_q),
    .wr_data_i   (mem_rdata_i),
    .alloc_i     (alloc),
    .alloc_tag_i (tag_q),
    .inv_i       (inv_i && (state_q == ST_IDLE))
  );

  icache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_set_i    (lk_idx),
    .victim_o    (victim),
    .touch_i     (touch),
    .touch_set_i (touch_set),
    .touch_way_i (touch_way)
  );

  always_comb begin
    state_d     = state_q;
    ack         = 1'b0;
    ack_port    = own_q;
    rdata       = hit_data;
    mem_req_o   = 1'b0;
    mem_burst_o = 1'b0;
    mem_addr_o  = '0;
    wr_en       = 1'b0;
    alloc       = 1'b0;
    touch       = 1'b0;
    touch_set   = lk_idx;
    touch_way   = hit_way;
    unique case (state_q)
      ST_IDLE: begin
        if (|gnt) begin
          if (en_i && hit) begin
            ack      = 1'b1;
            ack_port = gnt[1];
            touch    = 1'b1;
          end else begin
            mem_req_o   = 1'b1;
            mem_burst_o = en_i && !lock_i;
            mem_addr_o  = sel_addr & (mem_burst_o ? LINE_MASK : WORD_MASK);
            state_d     = mem_burst_o ? ST_FILL : ST_PASS;
          end
        end
      end
      ST_FILL: begin
        if (mem_rvalid_i) begin
          wr_en = 1'b1;
          if (beat_q == word_q && !sent_q) begin
            ack   = 1'b1;
            rdata = mem_rdata_i;
          end
          if (last_beat) begin
            alloc     = 1'b1;
            touch     = 1'b1;
            touch_set = idx_q;
            touch_way = way_q;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_PASS: begin
        if (mem_rvalid_i) begin
          ack     = 1'b1;
          rdata   = mem_rdata_i;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign i_ack_o   = ack && !ack_port;
  assign d_ack_o   = ack && ack_port;
  assign i_rdata_o = rdata;
  assign d_rdata_o = rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      own_q   <= 1'b0;
      idx_q   <= '0;
      tag_q   <= '0;
      word_q  <= '0;
      way_q   <= '0;
      beat_q  <= '0;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && mem_req_o) begin
        own_q  <= gnt[1];
        idx_q  <= lk_idx;
        tag_q  <= lk_tag;
        word_q <= lk_word;
        way_q  <= victim;
        beat_q <= '0;
        sent_q <= 1'b0;
      end else if (state_q == ST_FILL && mem_rvalid_i) begin
        beat_q <= beat_q + 1'b1;
        if (beat_q == word_q) sent_q <= 1'b1;
      end
    end
  end

  AST_ONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(i_ack_o && d_ack_o)); // R6
  AST_I_ACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_ack_o |-> i_req_i); // R2
  AST_D_ACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_ack_o |-> d_req_i); // R2
  AST_BURST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o) |-> (mem_addr_o[OFF_W-1:0] == '0)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R3
  AST_LOCK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && lock_i) |-> !mem_burst_o); // R7
  AST_OFF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !en_i) |-> !mem_burst_o); // R8
  AST_BUSY_NO_NEWREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !mem_req_o); // R11
endmodule

// File: tb/icache_ctrl_bench.sv
module icache_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, lock = 1'b0, inv = 1'b0;
  logic        i_req = 1'b0, d_req = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0;
  logic        i_ack, d_ack;
  logic [31:0] i_rdata, d_rdata;
  logic        mem_req, mem_burst, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;

  int cyc = 0, n_checks = 0, n_errors = 0;
  int n_burst = 0, n_single = 0;
  logic [31:0] last_base = '0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    int          lat;
    int          t0;
    string       rq;
  } exp_t;
  exp_t q_i[$], q_d[$];

  icache_ctrl u_icache_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .lock_i(lock), .inv_i(inv),
    .i_req_i(i_req), .i_addr_i(i_addr), .i_ack_o(i_ack), .i_rdata_o(i_rdata),
    .d_req_i(d_req), .d_addr_i(d_addr), .d_ack_o(d_ack), .d_rdata_o(d_rdata),
    .mem_req_o(mem_req), .mem_burst_o(mem_burst), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [31:0] memdata(input logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'h3C3C_5A5A;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model: two idle cycles, then beats on consecutive cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        automatic logic [31:0] base = mem_addr;
        automatic int n = mem_burst ? 8 : 1;
        last_base = base;
        if (mem_burst) n_burst++; else n_single++;
        repeat (2) @(posedge clk);
        for (int k = 0; k < n; k++) begin
          @(posedge clk); #1;
          mem_rvalid = 1'b1;
          mem_rdata  = memdata(base + 32'(4 * k));
        end
        @(posedge clk); #1;
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic pop_cmp(input bit p, input logic [31:0] data);
    exp_t e;
    if (p ? (q_d.size() == 0) : (q_i.size() == 0)) begin
      check(p ? "R6 unexpected d ack" : "R6 unexpected i ack", 32'd1, 32'd0);
      return;
    end
    e = p ? q_d.pop_front() : q_i.pop_front();
    check({e.rq, " data"}, data, e.data);
    check({e.rq, " latency"}, 32'(cyc - e.t0), 32'(e.lat));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (i_ack === 1'b1) pop_cmp(1'b0, i_rdata);
      if (d_ack === 1'b1) pop_cmp(1'b1, d_rdata);
    end
  end

  // driver: starts one cycle after a rising edge, returns the same way
  task automatic fetch(input bit p, input logic [31:0] a, input int lat, input string rq);
    exp_t e;
    e.data = memdata(a & 32'hFFFF_FFFC);
    e.lat  = lat;
    e.t0   = cyc;
    e.rq   = rq;
    if (p) begin q_d.push_back(e); d_addr = a; d_req = 1'b1; end
    else   begin q_i.push_back(e); i_addr = a; i_req = 1'b1; end
    forever begin
      @(negedge clk);
      if ((p ? d_ack : i_ack) === 1'b1) break;
    end
    @(posedge clk); #1;
    if (p) d_req = 1'b0; else i_req = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_inv();
    inv = 1'b1;
    @(posedge clk); #1;
    inv = 1'b0;
  endtask

  localparam logic [31:0] LA = 32'h0000_0040;  // set 2
  localparam logic [31:0] LB = 32'h0000_0840;
  localparam logic [31:0] LC = 32'h0000_1040;
  localparam logic [31:0] LD = 32'h0000_1840;
  localparam logic [31:0] LE = 32'h0000_2040;
  localparam logic [31:0] LF = 32'h0000_00A0;  // set 5
  localparam logic [31:0] LG = 32'h0000_00C4;  // set 6, word 1
  localparam logic [31:0] LH = 32'h0000_2840;

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    @(negedge clk);
    check("R10 i_ack after reset", 32'(i_ack), 0);
    check("R10 d_ack after reset", 32'(d_ack), 0);
    check("R10 mem_req after reset", 32'(mem_req), 0);
    @(posedge clk); #1;
    en = 1'b1;

    // R3 R10: cold miss, word 3, acked on beat 3
    fetch(0, LA + 32'h0C, 6, "R3 R10 cold miss");
    check("R3 line-aligned burst address", last_base, LA);
    settle(8);
    fetch(0, LA + 32'h1C, 0, "R2 hit same cycle");
    fetch(1, LA + 32'h00, 0, "R5 data-code port hits shared line");

    // R1 R4: fill remaining ways of set 2, then replacement order
    fetch(0, LB + 32'h04, 4, "R1 R4 fill way1"); settle(8);
    fetch(0, LC + 32'h08, 5, "R4 fill way2"); settle(8);
    fetch(0, LD + 32'h10, 7, "R4 fill way3"); settle(8);
    fetch(0, LA + 32'h14, 0, "R4 hit refreshes A");
    fetch(0, LE + 32'h18, 9, "R4 miss evicts LRU"); settle(8);
    fetch(0, LA, 0, "R4 A kept"); fetch(0, LC, 0, "R4 C kept");
    fetch(0, LD, 0, "R4 D kept"); fetch(0, LE, 0, "R4 E resident");
    fetch(0, LB + 32'h04, 4, "R4 B was evicted"); settle(8);
    fetch(0, LA + 32'h08, 5, "R4 A oldest evicted"); settle(8);
    check("R3 burst count", 32'(n_burst), 7);

    // R6: conflicts alternate
    fork
      fetch(0, LA, 0, "R6 conflict1 instr wins");
      fetch(1, LB, 1, "R6 conflict1 data waits");
    join
    fork
      fetch(0, LD, 1, "R6 conflict2 instr waits");
      fetch(1, LE, 0, "R6 conflict2 data wins");
    join
    fork
      fetch(0, LA + 32'h04, 0, "R6 conflict3 instr wins");
      fetch(1, LB + 32'h04, 1, "R6 conflict3 data waits");
    join

    // R11: other port stalls during a fill
    fork
      fetch(0, LF, 3, "R11 owner miss");
      begin
        @(posedge clk); #1;
        fetch(1, LA + 32'h0C, 10, "R11 stalled hit");
      end
    join
    settle(8);

    // R9: invalidate during fill ignored, in idle honoured
    fork
      fetch(0, LG, 4, "R9 fill with invalidate");
      begin repeat (3) @(posedge clk); #1; pulse_inv(); end
    join
    settle(8);
    fetch(0, LG, 0, "R9 filled line survives");
    fetch(1, LA, 0, "R9 older line survives");
    pulse_inv();
    fetch(0, LA + 32'h10, 7, "R9 miss after invalidate"); settle(8);
    check("R9 burst count", 32'(n_burst), 10);

    // R7: locked
    lock = 1'b1;
    fetch(0, LA + 32'h10, 0, "R7 locked hit");
    fetch(0, LH, 3, "R7 locked miss single");
    fetch(1, LH, 3, "R7 no allocation");
    fetch(0, LA + 32'h10, 0, "R7 no eviction");
    check("R7 single count", 32'(n_single), 2);
    check("R7 no burst while locked", 32'(n_burst), 10);
    check("R7 single word address", last_base, LH);
    lock = 1'b0;

    // R8: disabled
    en = 1'b0;
    fetch(0, LA + 32'h12, 3, "R8 bypass resident line");
    check("R8 word-aligned address", last_base, LA + 32'h10);
    en = 1'b1;
    fetch(0, LA + 32'h10, 0, "R8 contents kept");
    check("R8 single count", 32'(n_single), 3);
    check("R2 queues drained", 32'(q_i.size() + q_d.size()), 0);

    settle(2);
    finish_run();
  end
endmodule